// File: doc/BRIEF.md
# Address-Only Acknowledge Responder for a Two-Wire Bus

This block watches a shared open-drain two-wire serial bus (clock line and data line) without ever acting as its master. It finds the opening condition of every transfer, collects the first byte after it, and when the seven upper bits of that byte equal its own configured address, it pulls the data line low for the acknowledge clock. It drives nothing else. Every byte after the address, in either direction, is left alone and the responder waits for the next opening condition.

Both bus lines enter through a two-flop synchroniser. Edges and bus conditions are found on the synchronised samples. The only output is an enable for an external open-drain pull-down on the data line, and it comes from a register. The configured address byte uses the same layout as the address byte on the wire, and its lowest bit plays no part in the comparison.

Top module: `addr_ack_responder`

## Requirements
- R1: After a synchronous reset the pull-down enable `sda_pull` is 0, and it stays 0 while `rst` is high.
- R2: A START is the data line falling while the clock line is high. Without a START since reset or since the last STOP, clock pulses on the bus never cause `sda_pull` to go high.
- R3: After a START the responder samples the data line on each of the next eight clock rising edges, most significant bit first. Bits 7..1 of that byte form the 7-bit address and bit 0 gives the direction (1 = read, 0 = write).
- R4: When bits 7..1 of the received byte equal `own_addr[7:1]`, the data line is held low through the whole ninth clock. This applies to both read and write direction.
- R5: `own_addr[0]` has no effect on whether the responder acknowledges.
- R6: When bits 7..1 differ from `own_addr[7:1]`, `sda_pull` stays 0 for the ninth clock and for the rest of the transfer.
- R7: The acknowledge drive begins after the clock falling edge that ends the eighth bit and ends after the clock falling edge that ends the ninth bit. Each change reaches `sda_pull` within 4 `clk` cycles of the clock line changing at the input.
- R8: After an acknowledged address the responder neither acknowledges nor drives any data byte, in read or write direction.
- R9: A repeated START (SDA falling while SCL is high in the middle of a transfer) starts a new address phase. This holds after an acknowledged address, after a refused address, and partway through an address byte.
- R10: A STOP (data line rising while the clock line is high) returns the responder to idle. A partially received address is discarded, and later clock pulses without a new START produce no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw sample of the bus clock line |
| sda_in | input | 1 | Raw sample of the bus data line (wired-AND level) |
| own_addr | input | 8 | Configured address byte; bits 7..1 are compared, bit 0 is unused |
| sda_pull | output | 1 | Registered enable for the open-drain pull-down on the data line |

## Verification
For two configured addresses, one with bit 0 set and one with bit 0 clear, the bench sends all 256 possible address bytes. A comparator that included bit 0, or that skipped one direction, would refuse some of its own addresses. A comparator that was too loose would acknowledge a neighbour. Every matched address is followed by a data byte, so a design that also acknowledged data, or kept the pull-down past the ninth clock, is caught in the data bit right after the acknowledge. Directed sequences cut an address short with a STOP or a repeated START, and send clock pulses with no START. A responder that kept stale bit counts, or missed the repeated-START case, would acknowledge at the wrong time or not at all.

// File: rtl/ackr_pkg.sv
package ackr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_evt_t;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bus_event_det.sv
module bus_event_det
  import ackr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.start    = scl_s & scl_q &  sda_q & ~sda_s;
    evt.stop     = scl_s & scl_q & ~sda_q &  sda_s;
    evt.scl_rise =  scl_s & ~scl_q;
    evt.scl_fall = ~scl_s &  scl_q;
  end

endmodule

// File: rtl/addr_capture.sv
module addr_capture
  import ackr_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1,
  localparam int CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic              en,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] own_addr,
  output logic [ADDR_W-1:0] rx_addr,
  output logic              byte_done,
  output logic              hit
);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              unused_dir_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (evt.start) begin
      cnt   <= '0;
    end else if (en && evt.scl_rise && (cnt < CNT_W'(BYTE_W))) begin
      shreg <= {shreg[BYTE_W-2:0], sda_s};
      cnt   <= cnt + 1'b1;
    end
  end

  assign rx_addr        = shreg[BYTE_W-1:1];
  assign byte_done      = (cnt == CNT_W'(BYTE_W));
  assign hit            = (rx_addr == own_addr[BYTE_W-1:1]);
  assign unused_dir_bit = own_addr[0] ^ shreg[0];

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BYTE_W))
    else $error("bit counter past one byte");

endmodule

// File: rtl/addr_ack_responder.sv
module addr_ack_responder
  import ackr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [BYTE_W-1:0] own_addr,
  output logic              sda_pull
);

  logic [1:0]        line_s;
  logic              scl_s, sda_s;
  bus_evt_t          evt;
  phase_t            phase;
  logic [ADDR_W-1:0] rx_addr;
  logic              byte_done, hit;

  bit_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  bus_event_det i_det (
    .clk   (clk),
    .rst   (rst),
    .scl_s (scl_s),
    .sda_s (sda_s),
    .evt   (evt)
  );

  addr_capture #(.ADDR_W(ADDR_W)) i_cap (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .en        (phase == PH_ADDR),
    .sda_s     (sda_s),
    .own_addr  (own_addr),
    .rx_addr   (rx_addr),
    .byte_done (byte_done),
    .hit       (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      sda_pull <= 1'b0;
    end else if (evt.stop) begin
      phase    <= PH_IDLE;
      sda_pull <= 1'b0;
    end else if (evt.start) begin
      phase    <= PH_ADDR;
      sda_pull <= 1'b0;
    end else begin
      unique case (phase)
        PH_ADDR: if (evt.scl_fall && byte_done) begin
          phase    <= hit ? PH_ACK : PH_IDLE;
          sda_pull <= hit;
        end
        PH_ACK: if (evt.scl_fall) begin
          phase    <= PH_IDLE;
          sda_pull <= 1'b0;
        end
        default: begin
          phase    <= PH_IDLE;
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

  // R7: drive starts only while the synchronised clock line is low
  p_pull_rise_scl_low_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(!scl_s))
    else $error("pull-down asserted with clock high");

  // R7: release also happens with the clock line low
  p_pull_fall_scl_low_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull) |-> $past(!scl_s))
    else $error("pull-down released with clock high");

  // R4: the acknowledge level is steady while the clock is high
  p_pull_stable_high_r4: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull))
    else $error("pull-down changed during clock high");

  // R3: an acknowledge needs a complete address byte
  p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(byte_done))
    else $error("acknowledge before eight bits");

  // R5: the comparison uses the upper seven bits only
  p_ack_addr_match_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(rx_addr == own_addr[BYTE_W-1:1]))
    else $error("acknowledge for a foreign address");

endmodule

// File: tb/test_addr_ack_responder.sv
module test_addr_ack_responder;

  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [7:0] own_addr = 8'h00;
  logic       sda_pull;
  logic       bus_sda;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign bus_sda = sda_m & ~sda_pull;

  addr_ack_responder i_addr_ack_responder (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_m),
    .sda_in   (bus_sda),
    .own_addr (own_addr),
    .sda_pull (sda_pull)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic clk_bit(input logic b, output logic lo, output logic hi);
    sda_m = b; wclk(H - 1);
    lo = sda_pull; wclk(1);
    scl_m = 1'b1; wclk(H / 2);
    hi = sda_pull; wclk(H - H / 2);
    scl_m = 1'b0;
  endtask

  // eight bits with no pull expected, then the ninth (acknowledge) clock
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic lo, hi;
    int   stray = 0;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], lo, hi);
      stray += int'(lo) + int'(hi);
    end
    check({tag, " bits"}, stray, 0);
    clk_bit(1'b1, lo, hi);
    check({tag, " ack-low"}, int'(lo), int'(exp_ack));
    check({tag, " ack-high"}, int'(hi), int'(exp_ack));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic lo, hi;
    int   stray;
    wclk(5);
    check("R1 pull in reset", int'(sda_pull), 0);
    rst = 1'b0;
    wclk(4);
    check("R1 pull after reset", int'(sda_pull), 0);

    // R2 / R10: clocks with no START never acknowledge
    own_addr = 8'h5A;
    stray = 0;
    for (int i = 0; i < 18; i++) begin
      scl_m = 1'b0;
      clk_bit(i < 8 ? own_addr[7 - i] : 1'b1, lo, hi);
      stray += int'(lo) + int'(hi);
    end
    scl_m = 1'b1; sda_m = 1'b1; wclk(H);
    check("R2 no START no ack", stray, 0);

    // sweep every address byte against two configured values
    for (int k = 0; k < 2; k++) begin
      own_addr = (k == 0) ? 8'hA5 : 8'h3C;
      for (int t = 0; t < 256; t++) begin
        logic [7:0] tb8;
        logic       m;
        string      tg;
        tb8 = 8'(t);
        m = (tb8[7:1] == own_addr[7:1]);
        if (!m)               tg = "R6 mismatch";
        else if (own_addr[0]) tg = "R5 bit0 set";
        else if (tb8[0])      tg = "R4 read";
        else                  tg = "R4 write";
        do_start();
        send_byte(tb8, m, tg);
        if (m) send_byte(tb8[0] ? 8'hFF : ~tb8, 1'b0, "R8 data");
        else   send_byte(8'h00, 1'b0, "R6 rest");
        do_stop();
      end
    end

    // R7: release seen in the low phase after the ninth clock
    own_addr = 8'h90;
    do_start();
    send_byte(8'h90, 1'b1, "R7 ack");
    clk_bit(1'b1, lo, hi);
    check("R7 released next low", int'(lo), 0);
    check("R7 released next high", int'(hi), 0);
    do_stop();

    // R9: repeated START after refused, after acked, and mid-byte
    do_start();
    send_byte(8'h22, 1'b0, "R9 refused first");
    do_rstart();
    send_byte(8'h91, 1'b1, "R9 after refused");
    do_rstart();
    send_byte(8'h90, 1'b1, "R9 after acked");
    do_rstart();
    for (int i = 7; i >= 5; i--) clk_bit(own_addr[i], lo, hi);
    do_rstart();
    send_byte(8'h91, 1'b1, "R9 mid-byte");
    do_stop();

    // R10: STOP discards a partial address
    do_start();
    for (int i = 7; i >= 4; i--) clk_bit(own_addr[i], lo, hi);
    do_stop();
    stray = 0;
    for (int i = 0; i < 9; i++) begin
      scl_m = 1'b0;
      clk_bit(i < 5 ? own_addr[3 - (i % 4)] : 1'b1, lo, hi);
      stray += int'(lo) + int'(hi);
    end
    scl_m = 1'b1; sda_m = 1'b1; wclk(H);
    check("R10 idle after STOP", stray, 0);
    do_start();
    send_byte(8'h90, 1'b1, "R10 recovery");
    do_stop();
    check("R10 pull after STOP", int'(sda_pull), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule